// File: doc/BRIEF.md
# Dual-Clock Buffer with Programmable Threshold Flags

This block is a first-in first-out word buffer, nine bits per word, whose depth is a parameter taken from 256, 512, 1024, 2048, 4096 or 8192. A producer pushes words on its own write clock and a consumer pulls them on its own read clock. The two clocks may be one net, or they may run with no fixed phase relation. Each side is qualified by a pair of enables, and a side acts only when both enables of its pair are high. Words read out land in an output register. An output-enable input picks whether that register is presented on the data pins or the pins are held at zero with a drive-valid indication low; this stands in for a pad-level three-state driver.

Besides empty and full, the block raises two early-warning flags. One tells the consumer that few words remain. The other tells the producer that few free slots remain. Their margins come from two offset registers. Both hold 7 after reset, and a load strobe on the write port can overwrite them. The write and read positions cross clock domains as Gray-coded pointers through two-stage synchronisers, so each flag is computed in the domain that acts on it and errs on the safe side.

Top module: `sync_flag_fifo`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first operation, `empty`=1, `full`=0, `almost_empty`=1, `almost_full`=0 and the registered read word is 0. Both offsets return to 7 and the buffer holds no words.
- R2: A word is stored on a rising `wr_clk` edge only when `wr_en_a` and `wr_en_b` are both 1 and `ld_offset` is 0. With either enable at 0, nothing is stored.
- R3: A word is taken on a rising `rd_clk` edge only when `rd_en_a` and `rd_en_b` are both 1 and `empty` is 0. Words leave in the order they were stored, and the taken word appears in the output register just after that edge.
- R4: `empty` is 1 exactly when the read side's synchronised copy of the write position equals the read position. A stored word clears `empty` after the second `rd_clk` edge that follows its write edge.
- R5: `full` is 1 exactly when the write position leads the write side's synchronised copy of the read position by the depth. A write attempted while `full` is 1 is dropped, and no stored word changes.
- R6: A read attempted while `empty` is 1 is dropped: the read position and the output register keep their values.
- R7: `almost_empty` is 1 while the read-side word count is at most the almost-empty offset. With the default offset, that is 7 or fewer words.
- R8: `almost_full` is 1 while the write-side word count plus the almost-full offset is at least the depth. With the default offset, that is depth minus 7 or more words.
- R9: While `ld_offset` is 1, each `wr_clk` edge with both write enables at 1 copies `wr_data` into an offset register and stores no buffer word. The first such edge loads the almost-empty offset, the next loads the almost-full offset, and further edges keep alternating. Lowering `ld_offset` makes the next load start again at the almost-empty offset.
- R10: With `out_en` at 1, `rd_data` shows the output register and `rd_drive` is 1. With `out_en` at 0, `rd_data` is all zeros and `rd_drive` is 0. `out_en` never alters the buffer contents.
- R11: Each pointer copy carried across the clock boundary changes in at most one bit per source-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock, free running |
| rd_clk | input | 1 | Read-side clock, may equal `wr_clk` |
| rst_n | input | 1 | Asynchronous active-low reset of both sides |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| ld_offset | input | 1 | Steers enabled write edges into the offset registers |
| wr_data | input | 9 | Word to store, or offset value while loading |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Presents the output register on `rd_data` |
| rd_data | output | 9 | Read word, zero while `out_en` is low |
| rd_drive | output | 1 | High when `rd_data` is being driven |
| empty | output | 1 | No word visible to the read side |
| full | output | 1 | No free slot visible to the write side |
| almost_empty | output | 1 | Read-side count at or below its offset |
| almost_full | output | 1 | Write-side count within its offset of the depth |

## Verification
The bench builds the block with the default depth of 256 and drives both clock pins from one clock. This makes the two-edge pointer crossing deterministic, so a cycle-exact model can predict every flag transition and the lag between a write and the clearing of `empty`. At that depth the buffer fills within a few hundred cycles. Dropped writes at full, dropped reads at empty, custom offsets on either side of the default, and a reset that arrives while words are stored all come into reach.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int unsigned WORD_W         = 9;
  localparam int unsigned OFFSET_DEFAULT = 7;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {
    LD_AE = 1'b0,
    LD_AF = 1'b1
  } ld_slot_e;
endpackage

// File: rtl/sff_ptr_xfer.sv
module sff_ptr_xfer #(
  parameter int unsigned PW = 9
) (
  input  logic          src_clk,
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] src_nxt,
  output logic [PW-1:0] dst_bin
);
  function automatic logic [PW-1:0] to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  logic [PW-1:0] gray_q;
  logic [PW-1:0] meta_q;
  logic [PW-1:0] sync_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= to_gray(src_nxt);
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_q;
      sync_q <= meta_q;
    end
  end

  assign dst_bin = from_gray(sync_q);

  // R11
  gray_single_step_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    $onehot0(gray_q ^ $past(gray_q)));
endmodule

// File: rtl/sff_store.sv
module sff_store
  import sff_pkg::*;
#(
  parameter  int unsigned DEPTH = 256,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         q
);
  word_t mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/sff_wr_ctl.sv
module sff_wr_ctl
  import sff_pkg::*;
#(
  parameter  int unsigned DEPTH = 256,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_a,
  input  logic          en_b,
  input  logic          load,
  input  word_t         din,
  input  logic [PW-1:0] rbin_s,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wbin_nxt,
  output logic          wr_fire,
  output logic          full,
  output logic          almost_full,
  output word_t         ae_off
);
  function automatic logic af_zone(logic [PW-1:0] lvl, word_t off);
    return (32'(lvl) + 32'(off)) >= 32'(DEPTH);
  endfunction

  logic          both_en;
  logic          wr_req;
  logic [PW-1:0] wbin;
  logic [PW-1:0] wr_level;
  word_t         af_off;
  ld_slot_e      slot;

  assign both_en  = en_a & en_b;
  assign wr_req   = both_en & ~load;
  assign wr_level = wbin - rbin_s;
  assign full     = (wr_level == PW'(DEPTH));
  assign wr_fire  = wr_req & ~full;
  assign wbin_nxt = wbin + PW'(wr_fire);
  assign waddr    = wbin[AW-1:0];
  assign almost_full = af_zone(wr_level, af_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wbin <= '0;
    else        wbin <= wbin_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off <= WORD_W'(OFFSET_DEFAULT);
      af_off <= WORD_W'(OFFSET_DEFAULT);
      slot   <= LD_AE;
    end else if (!load) begin
      slot <= LD_AE;
    end else if (both_en) begin
      if (slot == LD_AE) ae_off <= din;
      else               af_off <= din;
      slot <= (slot == LD_AE) ? LD_AF : LD_AE;
    end
  end

  // R5
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req) |=> (wbin == $past(wbin)));

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_level <= PW'(DEPTH));

  // R9
  load_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wbin == $past(wbin)));
endmodule

// File: rtl/sff_rd_ctl.sv
module sff_rd_ctl
  import sff_pkg::*;
#(
  parameter  int unsigned DEPTH = 256,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_a,
  input  logic          en_b,
  input  logic [PW-1:0] wbin_s,
  input  word_t         ae_off,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rbin_nxt,
  output logic          rd_fire,
  output logic          empty,
  output logic          almost_empty
);
  function automatic logic ae_zone(logic [PW-1:0] lvl, word_t off);
    return 32'(lvl) <= 32'(off);
  endfunction

  logic          rd_req;
  logic [PW-1:0] rbin;
  logic [PW-1:0] rd_level;

  assign rd_req   = en_a & en_b;
  assign rd_level = wbin_s - rbin;
  assign empty    = (rd_level == '0);
  assign rd_fire  = rd_req & ~empty;
  assign rbin_nxt = rbin + PW'(rd_fire);
  assign raddr    = rbin[AW-1:0];
  assign almost_empty = ae_zone(rd_level, ae_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbin <= '0;
    else        rbin <= rbin_nxt;
  end

  // R6
  empty_read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req) |=> (rbin == $past(rbin)));

  // R3
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ((rbin - $past(rbin)) == PW'(1)));

  // R4
  read_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_level <= PW'(DEPTH));
endmodule

// File: rtl/sync_flag_fifo.sv
module sync_flag_fifo
  import sff_pkg::*;
#(
  parameter  int unsigned DEPTH = 256,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1
) (
  input  logic        wr_clk,
  input  logic        rd_clk,
  input  logic        rst_n,
  input  logic        wr_en_a,
  input  logic        wr_en_b,
  input  logic        ld_offset,
  input  logic [8:0]  wr_data,
  input  logic        rd_en_a,
  input  logic        rd_en_b,
  input  logic        out_en,
  output logic [8:0]  rd_data,
  output logic        rd_drive,
  output logic        empty,
  output logic        full,
  output logic        almost_empty,
  output logic        almost_full
);
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [PW-1:0] wbin_nxt;
  logic [PW-1:0] rbin_nxt;
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] rbin_s;
  logic          wr_fire;
  logic          rd_fire;
  word_t         ae_off;
  word_t         q_word;

  sff_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk         (wr_clk),
    .rst_n       (rst_n),
    .en_a        (wr_en_a),
    .en_b        (wr_en_b),
    .load        (ld_offset),
    .din         (wr_data),
    .rbin_s      (rbin_s),
    .waddr       (waddr),
    .wbin_nxt    (wbin_nxt),
    .wr_fire     (wr_fire),
    .full        (full),
    .almost_full (almost_full),
    .ae_off      (ae_off)
  );

  sff_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk          (rd_clk),
    .rst_n        (rst_n),
    .en_a         (rd_en_a),
    .en_b         (rd_en_b),
    .wbin_s       (wbin_s),
    .ae_off       (ae_off),
    .raddr        (raddr),
    .rbin_nxt     (rbin_nxt),
    .rd_fire      (rd_fire),
    .empty        (empty),
    .almost_empty (almost_empty)
  );

  sff_ptr_xfer #(.PW(PW)) u_w2r (
    .src_clk (wr_clk),
    .dst_clk (rd_clk),
    .rst_n   (rst_n),
    .src_nxt (wbin_nxt),
    .dst_bin (wbin_s)
  );

  sff_ptr_xfer #(.PW(PW)) u_r2w (
    .src_clk (rd_clk),
    .dst_clk (wr_clk),
    .rst_n   (rst_n),
    .src_nxt (rbin_nxt),
    .dst_bin (rbin_s)
  );

  sff_store #(.DEPTH(DEPTH)) u_mem (
    .wr_clk (wr_clk),
    .we     (wr_fire),
    .waddr  (waddr),
    .wdata  (wr_data),
    .rd_clk (rd_clk),
    .rst_n  (rst_n),
    .re     (rd_fire),
    .raddr  (raddr),
    .q      (q_word)
  );

  assign rd_data  = out_en ? q_word : '0;
  assign rd_drive = out_en;

  // R1
  reset_flags_chk: assert property (@(posedge wr_clk)
    !rst_n |-> (empty && !full && almost_empty && !almost_full));
endmodule

// File: tb/sim_sync_flag_fifo.sv
module sim_sync_flag_fifo;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wa = 1'b0, wb = 1'b0, ld = 1'b0;
  logic [8:0] din = '0;
  logic       ra = 1'b0, rb = 1'b0, oe = 1'b1;
  logic [8:0] rd_data;
  logic       rd_drive, empty, full, almost_empty, almost_full;

  always #2 clk = ~clk;

  sync_flag_fifo #(.DEPTH(DEPTH)) u0 (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .wr_en_a(wa), .wr_en_b(wb), .ld_offset(ld), .wr_data(din),
    .rd_en_a(ra), .rd_en_b(rb), .out_en(oe),
    .rd_data(rd_data), .rd_drive(rd_drive), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "init";

  // reference model state
  int m_wc, m_rc, m_wc1, m_wc2, m_rc1, m_rc2;
  int m_ae, m_af;
  bit m_sel_af;
  logic [8:0] m_q;
  logic [8:0] m_store[$];

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s phase=%s actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wc = 0; m_rc = 0; m_wc1 = 0; m_wc2 = 0; m_rc1 = 0; m_rc2 = 0;
    m_ae = 7; m_af = 7; m_sel_af = 0; m_q = '0;
    m_store.delete();
  endtask

  task automatic compare_all();
    check_val("R4 empty", int'(empty), int'(m_rc == m_wc2));
    check_val("R5 full", int'(full), int'((m_wc - m_rc2) == DEPTH));
    check_val("R7 almost_empty", int'(almost_empty), int'((m_wc2 - m_rc) <= m_ae));
    check_val("R8 almost_full", int'(almost_full), int'((m_wc - m_rc2) + m_af >= DEPTH));
    check_val("R3 rd_data", int'(rd_data), oe ? int'(m_q) : 0);
    check_val("R10 rd_drive", int'(rd_drive), int'(oe));
  endtask

  task automatic step(bit iwa, bit iwb, bit ild, int idin, bit ira, bit irb, bit ioe);
    bit was_full, was_empty;
    wa = iwa; wb = iwb; ld = ild; din = 9'(idin); ra = ira; rb = irb; oe = ioe;
    @(posedge clk);
    was_full  = (m_wc - m_rc2) == DEPTH;
    was_empty = (m_rc == m_wc2);
    m_wc2 = m_wc1; m_wc1 = m_wc;
    m_rc2 = m_rc1; m_rc1 = m_rc;
    if (iwa && iwb) begin
      if (ild) begin
        if (!m_sel_af) m_ae = idin & 9'h1ff;
        else           m_af = idin & 9'h1ff;
        m_sel_af = ~m_sel_af;
      end else if (!was_full) begin
        m_store.push_back(9'(idin));
        m_wc++;
      end
    end
    if (!ild) m_sel_af = 0;
    if (ira && irb && !was_empty) begin
      m_q = m_store.pop_front();
      m_rc++;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic write_n(int n, int base);
    for (int i = 0; i < n; i++) step(1, 1, 0, (base + i) % 512, 0, 0, 1);
  endtask

  task automatic read_n(int n, bit toggle_oe);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 1, toggle_oe ? bit'(i % 2) : 1'b1);
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic apply_reset();
    phase = "R1 reset";
    wa = 0; wb = 0; ld = 0; ra = 0; rb = 0; oe = 1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    // R1: flag and data values while reset is held
    check_val("R1 empty", int'(empty), 1);
    check_val("R1 full", int'(full), 0);
    check_val("R1 almost_empty", int'(almost_empty), 1);
    check_val("R1 almost_full", int'(almost_full), 0);
    check_val("R1 rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    idle_n(2);
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog phase=%s actual=%0d expected=<200000", phase, cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stimulus
    model_reset();
    apply_reset();

    // R2: one enable alone stores nothing
    phase = "R2 single enable";
    for (int i = 0; i < 4; i++) step(1, 0, 0, 100 + i, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 200 + i, 0, 0, 1);
    idle_n(3);

    // R2 R4: ten words, empty clears two edges after the first write
    phase = "R2 R4 write ten";
    write_n(10, 300);
    idle_n(3);

    // R3: single read enable takes nothing; then ordered read-out
    phase = "R3 single read enable";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 1);
    phase = "R3 R6 read out and overread";
    read_n(13, 0);
    idle_n(2);

    // R5 R8: fill past capacity, extra writes dropped
    phase = "R5 R8 fill";
    write_n(262, 5);
    idle_n(3);
    // R10: drain with output enable toggling
    phase = "R10 drain";
    read_n(258, 1);
    idle_n(3);

    // R9: two load strobes set AE then AF, single-enable load ignored
    phase = "R9 load pair";
    step(1, 1, 1, 20, 0, 0, 1);
    step(1, 1, 1, 30, 0, 0, 1);
    step(1, 0, 1, 99, 0, 0, 1);
    idle_n(2);
    write_n(25, 40);
    idle_n(3);
    phase = "R7 custom ae drain";
    read_n(25, 0);
    idle_n(3);

    // R9: dropping load restarts at the almost-empty slot
    phase = "R9 restart";
    step(1, 1, 1, 5, 0, 0, 1);
    idle_n(1);
    step(1, 1, 1, 200, 0, 0, 1);
    idle_n(2);
    phase = "R8 custom af";
    write_n(230, 7);
    idle_n(3);

    // R1: reset with data stored restores defaults
    apply_reset();
    phase = "R1 R8 defaults after reset";
    write_n(250, 11);
    idle_n(3);
    phase = "R7 default ae";
    read_n(245, 0);
    idle_n(3);

    // R3 R4: concurrent streaming
    phase = "R3 stream";
    for (int i = 0; i < 60; i++) step(1, 1, 0, 400 + i, 1, 1, 1);
    read_n(6, 0);
    idle_n(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule